// File: doc/BRIEF.md
# Paged Non-Volatile Memory Write Sequencer

This block carries out writes into a paged non-volatile memory at the CPU's request while the user program keeps running. Software first selects a page with a page-select strobe. It then issues one of two commands. A byte write carries an offset within the page and one data byte. A block write carries a block index and copies the first 32 entries of the register file into one aligned 32-byte block of the selected page.

Each accepted write holds the CPU stalled for a programmable write time, derived from the clock rate and a duration in microseconds, and then commits the bytes to the memory port, one byte per cycle. An interrupt request during a write ends it early and raises an abort flag. A consecutive window of protected pages, bounded by a lock page and an unlock page, rejects writes and raises a protection flag. An external programming mode input bypasses that window.

Top module: `nvm_write_seq`

## Requirements
- R1: After reset, busy, cpu_stall, st_abort, st_prot and mem_we are all low.
- R2: A pg_set strobe while idle loads pg_num as the current page; a pg_set strobe while busy has no effect.
- R3: An accepted byte write holds busy and cpu_stall high for exactly WAIT+1 cycles and writes byte_data once, in the last busy cycle, to address page*256 + byte_ofs.
- R4: An accepted block write reads register-file addresses 0 to 31 with one cycle of read latency, holds busy for exactly WAIT+33 cycles and writes all 32 bytes in ascending order to page*256 + block*32 + i, with byte i taken from register-file entry i.
- R5: Only the low 3 bits of blk_idx select the block; index 12 writes block 4.
- R6: A command for a page p with lock_pg <= p < unlock_pg is rejected while ext_prog_mode is low: no write, busy stays low, and st_prot is high from the next cycle.
- R7: When lock_pg equals unlock_pg, or lock_pg exceeds unlock_pg, no page is protected.
- R8: With ext_prog_mode high, pages inside the protection window are written normally.
- R9: irq_req high during a write ends it at the next clock edge: busy falls, st_abort rises, and no further byte is written.
- R10: Every command that is accepted or rejected clears st_abort and st_prot. Between commands both hold their values.
- R11: When byte_go and blk_go are high together, only the byte write is performed. Commands arriving while busy are ignored.
- R12: The wait time is WAIT = CLK_KHZ*WRITE_US/1000 cycles, which is 225000 cycles for 4.5 ms at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_set | input | 1 | Page-select strobe |
| pg_num | input | PG_W | Page number loaded by pg_set |
| byte_go | input | 1 | Start a single-byte write |
| byte_ofs | input | OFS_W | Byte offset within the page |
| byte_data | input | DW | Data for the single-byte write |
| blk_go | input | 1 | Start a 32-byte block write |
| blk_idx | input | BIDX_W | Block index; only the low bits are used |
| irq_req | input | 1 | Interrupt request; aborts a write in progress |
| ext_prog_mode | input | 1 | External programming mode; bypasses protection |
| lock_pg | input | PG_W | First protected page |
| unlock_pg | input | PG_W | First unprotected page after the window |
| rf_addr | output | BLK_W | Register-file read address |
| rf_rdata | input | DW | Register-file read data, one cycle after rf_addr |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | PG_W+OFS_W | Linear memory byte address |
| mem_wdata | output | DW | Memory write data |
| cpu_stall | output | 1 | Holds CPU execution |
| busy | output | 1 | Write in progress |
| st_abort | output | 1 | Last write was aborted by an interrupt |
| st_prot | output | 1 | Last command hit the protected window |

## Verification
A wrong wait counter shows up at the ports as a busy interval that is too long or too short, so the bench measures it against WAIT+1 or WAIT+33 on every operation. A wrong page, offset or block register, or a wrong commit beat counter, shows up as a wrong, missing or extra write address or data byte. The scoreboard catches this on the cycle the write appears. A wrong protection or abort decision appears within one cycle of the command or the interrupt, as a busy line that should not have risen or should have fallen, or as a status flag with the wrong value.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_WAIT   = 2'd1,
      WS_COMMIT = 2'd2
   } wr_state_e;

   typedef enum logic {
      WM_BYTE  = 1'b0,
      WM_BLOCK = 1'b1
   } wr_mode_e;

   // Wait length in clock cycles for a duration in microseconds.
   function automatic int unsigned wait_cycles(input int unsigned khz,
                                               input int unsigned us);
      return (khz * us) / 1000;
   endfunction

endpackage

// File: rtl/nvm_wait_timer.sv
module nvm_wait_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("nvm_wait_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = run && (cnt_q == '0);

   // R12
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD_VAL);

   // R12
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && $past(run) && !$past(load) && ($past(cnt_q) != '0))
         |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nvm_prot_check.sv
module nvm_prot_check #(
   parameter int unsigned PG_W = 5
) (
   input  logic [PG_W-1:0] page,
   input  logic [PG_W-1:0] lock_pg,
   input  logic [PG_W-1:0] unlock_pg,
   input  logic            bypass,
   output logic            blocked
);
   if (PG_W < 1) begin : g_bad_pg
      $error("nvm_prot_check: PG_W must be at least 1");
   end

   logic win_open;
   logic above_lo;
   logic below_hi;

   always_comb begin
      win_open = (lock_pg < unlock_pg);
      above_lo = (page >= lock_pg);
      below_hi = (page < unlock_pg);
      blocked  = win_open && above_lo && below_hi && !bypass;
   end

endmodule

// File: rtl/nvm_addr_gen.sv
module nvm_addr_gen #(
   parameter int unsigned PG_W  = 5,
   parameter int unsigned OFS_W = 8,
   parameter int unsigned BLK_W = 5
) (
   input  logic [PG_W-1:0]            page,
   input  logic                       is_blk,
   input  logic [OFS_W-1:0]           ofs,
   input  logic [OFS_W-BLK_W-1:0]     blk_sel,
   input  logic [BLK_W-1:0]           beat,
   output logic [PG_W+OFS_W-1:0]      addr
);
   if (BLK_W >= OFS_W) begin : g_bad_blk
      $error("nvm_addr_gen: a block must be smaller than a page");
   end

   logic [OFS_W-1:0] blk_ofs;
   assign blk_ofs = {blk_sel, beat};
   assign addr    = {page, (is_blk ? blk_ofs : ofs)};

endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
   import nvm_wr_pkg::*;
#(
   parameter int unsigned PG_W     = 5,
   parameter int unsigned OFS_W    = 8,
   parameter int unsigned BLK_W    = 5,
   parameter int unsigned BIDX_W   = 8,
   parameter int unsigned DW       = 8,
   parameter int unsigned CLK_KHZ  = 50000,
   parameter int unsigned WRITE_US = 4500
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pg_set,
   input  logic [PG_W-1:0]       pg_num,
   input  logic                  byte_go,
   input  logic [OFS_W-1:0]      byte_ofs,
   input  logic [DW-1:0]         byte_data,
   input  logic                  blk_go,
   input  logic [BIDX_W-1:0]     blk_idx,
   input  logic                  irq_req,
   input  logic                  ext_prog_mode,
   input  logic [PG_W-1:0]       lock_pg,
   input  logic [PG_W-1:0]       unlock_pg,
   output logic [BLK_W-1:0]      rf_addr,
   input  logic [DW-1:0]         rf_rdata,
   output logic                  mem_we,
   output logic [PG_W+OFS_W-1:0] mem_addr,
   output logic [DW-1:0]         mem_wdata,
   output logic                  cpu_stall,
   output logic                  busy,
   output logic                  st_abort,
   output logic                  st_prot
);
   localparam int unsigned ADDR_W     = PG_W + OFS_W;
   localparam int unsigned SEL_W      = OFS_W - BLK_W;
   localparam int unsigned BLK_BYTES  = 1 << BLK_W;
   localparam int unsigned BLKS_PG    = 1 << SEL_W;
   localparam int unsigned WAIT       = wait_cycles(CLK_KHZ, WRITE_US);
   localparam logic [BLK_W:0] LAST_BEAT = (BLK_W+1)'(BLK_BYTES);

   if (WAIT < 1) begin : g_bad_wait
      $error("nvm_write_seq: CLK_KHZ*WRITE_US must give at least one cycle");
   end
   if (BLK_W >= OFS_W) begin : g_bad_geom
      $error("nvm_write_seq: BLK_W must be below OFS_W");
   end
   if (BIDX_W < SEL_W) begin : g_bad_bidx
      $error("nvm_write_seq: BIDX_W too narrow for the block select");
   end

   wr_state_e         state_q;
   wr_mode_e          mode_q;
   logic [PG_W-1:0]   page_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DW-1:0]     data_q;
   logic [SEL_W-1:0]  blk_q;
   logic [BLK_W:0]    beat_q;
   logic              abort_q;
   logic              prot_q;

   logic              go_any;
   logic              blocked;
   logic              accept;
   logic              tmr_done;
   logic [SEL_W-1:0]  blk_trunc;
   logic [BLK_W-1:0]  wr_beat;

   assign go_any    = byte_go || blk_go;
   assign accept    = (state_q == WS_IDLE) && go_any && !blocked;
   assign blk_trunc = SEL_W'(blk_idx % BIDX_W'(BLKS_PG));
   assign wr_beat   = BLK_W'(beat_q - 1'b1);

   nvm_prot_check #(.PG_W(PG_W)) u_prot (
      .page      (page_q),
      .lock_pg   (lock_pg),
      .unlock_pg (unlock_pg),
      .bypass    (ext_prog_mode),
      .blocked   (blocked)
   );

   nvm_wait_timer #(.CYCLES(WAIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .run   (state_q == WS_WAIT),
      .done  (tmr_done)
   );

   nvm_addr_gen #(.PG_W(PG_W), .OFS_W(OFS_W), .BLK_W(BLK_W)) u_addr (
      .page    (page_q),
      .is_blk  (mode_q == WM_BLOCK),
      .ofs     (ofs_q),
      .blk_sel (blk_q),
      .beat    (wr_beat),
      .addr    (mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         mode_q  <= WM_BYTE;
         page_q  <= '0;
         ofs_q   <= '0;
         data_q  <= '0;
         blk_q   <= '0;
         beat_q  <= '0;
         abort_q <= 1'b0;
         prot_q  <= 1'b0;
      end else begin
         case (state_q)
            WS_IDLE: begin
               if (go_any) begin
                  abort_q <= 1'b0;
                  prot_q  <= blocked;
                  if (!blocked) begin
                     state_q <= WS_WAIT;
                     mode_q  <= byte_go ? WM_BYTE : WM_BLOCK;
                     ofs_q   <= byte_ofs;
                     data_q  <= byte_data;
                     blk_q   <= blk_trunc;
                  end
               end else if (pg_set) begin
                  page_q <= pg_num;
               end
            end
            WS_WAIT: begin
               if (irq_req) begin
                  state_q <= WS_IDLE;
                  abort_q <= 1'b1;
               end else if (tmr_done) begin
                  state_q <= WS_COMMIT;
                  beat_q  <= '0;
               end
            end
            WS_COMMIT: begin
               if (irq_req) begin
                  state_q <= WS_IDLE;
                  abort_q <= 1'b1;
               end else if ((mode_q == WM_BYTE) || (beat_q == LAST_BEAT)) begin
                  state_q <= WS_IDLE;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != WS_IDLE);
   assign cpu_stall = busy;
   assign st_abort  = abort_q;
   assign st_prot   = prot_q;
   assign rf_addr   = beat_q[BLK_W-1:0];
   assign mem_we    = (state_q == WS_COMMIT) &&
                      ((mode_q == WM_BYTE) || (beat_q != '0));
   assign mem_wdata = (mode_q == WM_BYTE) ? data_q : rf_rdata;

   // R9
   abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_abort) |-> ($past(busy) && $past(irq_req)));

   // R6
   prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(ext_prog_mode) || !$past(blocked)));

   // R2
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(page_q));

   // R3
   done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(irq_req)) |-> $past(mem_we));

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && (mode_q == WM_BLOCK) && $past(mem_we))
         |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // R9
   no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);

endmodule

// File: tb/test_nvm_write_seq.sv
module test_nvm_write_seq;
   localparam int PG_W  = 5;
   localparam int OFS_W = 8;
   localparam int AW    = PG_W + OFS_W;
   localparam int WAIT  = 15;   // 10 kHz * 1500 us / 1000

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pg_set = 1'b0;
   logic [PG_W-1:0] pg_num = '0;
   logic byte_go = 1'b0;
   logic [7:0] byte_ofs = '0;
   logic [7:0] byte_data = '0;
   logic blk_go = 1'b0;
   logic [7:0] blk_idx = '0;
   logic irq_req = 1'b0;
   logic ext_prog_mode = 1'b0;
   logic [PG_W-1:0] lock_pg = '0;
   logic [PG_W-1:0] unlock_pg = '0;
   logic [4:0] rf_addr;
   logic [7:0] rf_rdata = '0;
   logic mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata;
   logic cpu_stall, busy, st_abort, st_prot;

   int n_tests = 0;
   int n_fail  = 0;
   bit done_flag = 1'b0;

   logic [7:0] rf_mem [32];
   logic [AW+7:0] exp_q [$];

   always #10 clk = ~clk;

   nvm_write_seq #(.CLK_KHZ(10), .WRITE_US(1500)) i_nvm_write_seq (
      .clk(clk), .rst_n(rst_n), .pg_set(pg_set), .pg_num(pg_num),
      .byte_go(byte_go), .byte_ofs(byte_ofs), .byte_data(byte_data),
      .blk_go(blk_go), .blk_idx(blk_idx), .irq_req(irq_req),
      .ext_prog_mode(ext_prog_mode), .lock_pg(lock_pg), .unlock_pg(unlock_pg),
      .rf_addr(rf_addr), .rf_rdata(rf_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cpu_stall(cpu_stall),
      .busy(busy), .st_abort(st_abort), .st_prot(st_prot)
   );

   // Register file model, one cycle read latency
   always @(posedge clk) rf_rdata <= rf_mem[rf_addr];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor: pops expected writes as they appear
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3/R4", "unexpected write addr", int'(mem_addr), 0);
         end else begin
            logic [AW+7:0] e;
            e = exp_q.pop_front();
            check({mem_addr, mem_wdata} == e, "R3/R4", "write addr+data",
                  int'({mem_addr, mem_wdata}), int'(e));
         end
      end
   end

   task automatic set_page(input int p);
      @(negedge clk); pg_set = 1'b1; pg_num = PG_W'(p);
      @(negedge clk); pg_set = 1'b0;
   endtask

   task automatic wait_idle(output int cnt);
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); end
   endtask

   task automatic push_block(input int p, input int b);
      for (int i = 0; i < 32; i++)
         exp_q.push_back({AW'(p*256 + b*32 + i), rf_mem[i]});
   endtask

   task automatic byte_wr(input int p, input int ofs, input int d, input string req);
      int cnt;
      exp_q.push_back({AW'(p*256 + ofs), 8'(d)});
      @(negedge clk); byte_go = 1'b1; byte_ofs = 8'(ofs); byte_data = 8'(d);
      @(negedge clk); byte_go = 1'b0;
      wait_idle(cnt);
      check(cnt == WAIT + 1, req, "byte busy length R12", cnt, WAIT + 1);
      check(exp_q.size() == 0, req, "byte write count", exp_q.size(), 0);
      check(!st_abort && !st_prot, req, "status after byte R10",
            {st_abort, st_prot}, 0);
   endtask

   task automatic block_wr(input int p, input int idx, input int eff, input string req);
      int cnt;
      push_block(p, eff);
      @(negedge clk); blk_go = 1'b1; blk_idx = 8'(idx);
      @(negedge clk); blk_go = 1'b0;
      wait_idle(cnt);
      check(cnt == WAIT + 33, req, "block busy length R12", cnt, WAIT + 33);
      check(exp_q.size() == 0, req, "block write count", exp_q.size(), 0);
   endtask

   task automatic rejected(input bit blk, input string req);
      @(negedge clk); if (blk) blk_go = 1'b1; else byte_go = 1'b1;
      @(negedge clk); blk_go = 1'b0; byte_go = 1'b0;
      check(!busy && st_prot && !st_abort, req, "rejected: busy,prot,abort",
            {busy, st_prot, st_abort}, 3'b010);
      repeat (WAIT + 40) @(negedge clk);
      check(exp_q.size() == 0 && !busy, req, "rejected: no activity", busy, 0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) rf_mem[i] = 8'(8'hA0 + i * 7);
      repeat (3) @(negedge clk);
      // R1
      check(!busy && !cpu_stall && !st_abort && !st_prot && !mem_we, "R1",
            "reset outputs", {busy, cpu_stall, st_abort, st_prot, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 single byte
      set_page(5);
      check(!busy, "R2", "page set leaves idle", busy, 0);
      byte_wr(5, 8'h12, 8'h3C, "R3");
      check(!cpu_stall, "R3", "stall released", cpu_stall, 0);

      // R4 block page 5 block 4 -> 0x580..0x59F
      block_wr(5, 4, 4, "R4");

      // R5 alias: index 12 -> block 4 on page 2
      set_page(2);
      block_wr(2, 12, 4, "R5");

      // R11 both strobes: byte only
      begin
         int cnt;
         exp_q.push_back({AW'(2*256 + 8'h40), 8'h77});
         @(negedge clk); byte_go = 1'b1; blk_go = 1'b1; byte_ofs = 8'h40;
         byte_data = 8'h77; blk_idx = 8'd1;
         @(negedge clk); byte_go = 1'b0; blk_go = 1'b0;
         // R11 commands while busy ignored; R2 page set while busy ignored
         repeat (3) @(negedge clk);
         blk_go = 1'b1; pg_set = 1'b1; pg_num = 5'd9;
         @(negedge clk); blk_go = 1'b0; pg_set = 1'b0;
         wait_idle(cnt);
         check(cnt == WAIT + 1 - 4, "R11", "byte-priority busy tail", cnt, WAIT - 3);
         repeat (WAIT + 40) @(negedge clk);
         check(exp_q.size() == 0 && !busy, "R11", "no extra write", busy, 0);
      end
      byte_wr(2, 8'h41, 8'h55, "R2");   // page must still be 2

      // R6 protection window [3,6)
      lock_pg = 5'd3; unlock_pg = 5'd6;
      set_page(5);
      rejected(1'b1, "R6");
      set_page(3);
      rejected(1'b0, "R6");
      set_page(6);
      byte_wr(6, 8'h01, 8'h11, "R6");
      set_page(2);
      byte_wr(2, 8'hFF, 8'h22, "R6");

      // R8 external programming bypass
      set_page(4);
      ext_prog_mode = 1'b1;
      byte_wr(4, 8'h09, 8'h99, "R8");
      ext_prog_mode = 1'b0;

      // R7 equal and inverted bounds
      lock_pg = 5'd4; unlock_pg = 5'd4;
      byte_wr(4, 8'h0A, 8'h98, "R7");
      lock_pg = 5'd6; unlock_pg = 5'd2;
      byte_wr(4, 8'h0B, 8'h97, "R7");
      lock_pg = 5'd0; unlock_pg = 5'd0;

      // R9 abort during wait
      begin
         @(negedge clk); blk_go = 1'b1; blk_idx = 8'd0;
         @(negedge clk); blk_go = 1'b0;
         repeat (4) @(negedge clk);
         irq_req = 1'b1;
         @(negedge clk); irq_req = 1'b0;
         check(!busy && st_abort && !st_prot, "R9", "abort in wait",
               {busy, st_abort, st_prot}, 3'b010);
         repeat (WAIT + 40) @(negedge clk);
         check(exp_q.size() == 0 && !busy, "R9", "no write after abort", busy, 0);
         check(st_abort, "R10", "abort flag holds", st_abort, 1);
      end

      // R9 abort during commit: bytes 0..2 land
      begin
         exp_q.push_back({AW'(4*256 + 7*32 + 0), rf_mem[0]});
         exp_q.push_back({AW'(4*256 + 7*32 + 1), rf_mem[1]});
         exp_q.push_back({AW'(4*256 + 7*32 + 2), rf_mem[2]});
         @(negedge clk); blk_go = 1'b1; blk_idx = 8'd7;
         @(negedge clk); blk_go = 1'b0;
         check(!st_abort, "R10", "command clears abort", st_abort, 0);
         repeat (WAIT + 3) @(negedge clk);
         irq_req = 1'b1;
         @(negedge clk); irq_req = 1'b0;
         check(!busy && st_abort, "R9", "abort in commit", {busy, st_abort}, 2'b01);
         repeat (40) @(negedge clk);
         check(exp_q.size() == 0, "R9", "partial block count", exp_q.size(), 0);
      end

      // R10 rejected command clears abort, next good one clears prot
      lock_pg = 5'd4; unlock_pg = 5'd5;
      rejected(1'b0, "R10");
      lock_pg = 5'd0; unlock_pg = 5'd0;
      byte_wr(4, 8'h33, 8'h44, "R10");

      check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule